// File: doc/BRIEF.md
# Word/Byte ALU Execute Unit

This block is the execute stage for the register and constant instructions of a 16-bit processor. Each accepted instruction arrives with the current destination register value, the current source register value and the status word. One clock later the block presents the value to write back, a write enable and the updated status. A swap instruction also presents a second write-back value for the source register. The surrounding pipeline supplies the operands and writes the register file from the instruction's own fields. Memory access and sequencing belong to other stages.

Two-operand operations can take their source from a register or from a small table of encoded constants. Each of them can work on the full 16-bit word or only on the low byte. In byte mode the destination's high byte is returned unchanged. The block also handles these operations:
- the single-operand moves, swaps, shifts, rotates and sign extension
- the four byte-immediate loads

Any instruction outside the recognised set causes no write-back and leaves the status unchanged.

Top module: `wb_alu_exec`

## Requirements
- R1: Results, write enables and status appear one cycle after `in_valid`, qualified by `out_valid`. When `out_valid` is low, `wr_en` and `wr2_en` are low. Reset clears `out_valid`, `wr_en`, `wr2_en`, `result` and `psw_out`.
- R2: For two-operand instructions (bits 15:12 = 0100), bit 7 set replaces the source register with an encoded constant. The constant is chosen by bits 5:3 in the order 0, 1, 2, 4, 8, 16, 32, 0xFFFF.
- R3: Bits 11:8 = 0000 to 0011 select ADD, ADDC, SUB (DST + ~SRC + 1) and SUBC (DST + ~SRC + C). The status word is {V,N,Z,C} in bits 3:0. C is the carry out of the top bit. V is signed overflow. Z is set for a zero result. N is the result's top bit.
- R4: With bit 6 set, a two-operand operation uses only the low bytes of its operands. The result's high byte equals the destination's high byte, and C, Z, N and V are taken from bit 7 and the low byte.
- R5: Bits 11:8 = 0110, 0111, 1001 and 1010 select XOR, AND, bit clear (DST & ~SRC) and bit set (DST | SRC). These update Z and N, clear V and keep C.
- R6: Bits 11:8 = 1000 (bit test) update the status as AND does, with no write-back.
- R7: 0100 1100 0Wsss ddd moves the source register (low byte only when W=1) without changing status. 0100 1100 10sss ddd writes the source to the destination and the destination to `wr2_data`, with `wr2_en` set and status kept.
- R8: 0100 1101 0W000ddd shifts the destination right arithmetically by one bit. 0100 1101 1W000ddd rotates it right through C. Both load C from the bit shifted out, update Z and N at the selected width and keep V.
- R9: 0100 1110 00000ddd swaps the destination's bytes with status kept. 0100 1110 00001ddd sign-extends its low byte to a word and updates Z and N, keeping C and V.
- R10: For bits 15:13 = 011, the immediate is bits 10:3 and bits 12:11 select the load. 00 sets the low byte and keeps the high byte. 01 sets the low byte and zeroes the high byte. 10 sets the low byte and fills the high byte with 0xFF. 11 sets the high byte and keeps the low byte. Status is unchanged.
- R11: Every other encoding gives `wr_en` low, `wr2_en` low and `psw_out` equal to `psw_in`. This includes unused bits 11:8 codes, nonzero fixed fields and instructions outside 010x/011x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands valid this cycle |
| instr | input | 16 | Instruction word |
| dst_val | input | 16 | Current destination register value |
| src_val | input | 16 | Current source register value |
| psw_in | input | 4 | Current status {V,N,Z,C} |
| out_valid | output | 1 | Result outputs valid |
| result | output | 16 | Value for the destination register |
| wr_en | output | 1 | Write `result` to the destination register |
| wr2_en | output | 1 | Write `wr2_data` to the source register (swap only) |
| wr2_data | output | 16 | Former destination value for a swap |
| psw_out | output | 4 | New status {V,N,Z,C} |

## Verification
The decode and the status logic are combinational, so a wrong operand choice, width or carry shows up on `result` or `psw_out` in the first valid cycle after the offending instruction. A wrong flag hides until a later operation that depends on it, so the bench compares every status bit on every instruction. The corrupting operations are those that must keep the high byte, the status or the write enable. Assertions watch these operations at the cycle the result leaves the block, and a scoreboard cross-checks several hundred mixed encodings against a separately written model.

// File: rtl/wb_alu_exec.sv
module wb_alu_exec #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] instr,
  input  logic [WIDTH-1:0] dst_val,
  input  logic [WIDTH-1:0] src_val,
  input  logic [3:0]       psw_in,
  output logic             out_valid,
  output logic [WIDTH-1:0] result,
  output logic             wr_en,
  output logic             wr2_en,
  output logic [WIDTH-1:0] wr2_data,
  output logic [3:0]       psw_out
);
  localparam int HB = WIDTH / 2;

  logic [WIDTH-1:0] konst;
  always_comb begin
    case (instr[5:3])
      3'd0:    konst = 16'h0000;
      3'd1:    konst = 16'h0001;
      3'd2:    konst = 16'h0002;
      3'd3:    konst = 16'h0004;
      3'd4:    konst = 16'h0008;
      3'd5:    konst = 16'h0010;
      3'd6:    konst = 16'h0020;
      default: konst = 16'hFFFF;
    endcase
  end

  wire             is_two = instr[15:12] == 4'b0100;
  wire             is_imm = instr[15:13] == 3'b011;
  wire [3:0]       op     = instr[11:8];
  wire             bmode  = instr[6];
  wire [WIDTH-1:0] opnd   = instr[7] ? konst : src_val;
  wire [WIDTH-1:0] bsel   = op[1] ? ~opnd : opnd;
  wire             cin    = op[0] ? psw_in[0] : op[1];
  wire [WIDTH:0]   wsum   = {1'b0, dst_val} + {1'b0, bsel} + {{WIDTH{1'b0}}, cin};
  wire [HB:0]      bsum   = {1'b0, dst_val[HB-1:0]} + {1'b0, bsel[HB-1:0]} + {{HB{1'b0}}, cin};
  wire [HB-1:0]    imm    = instr[10:3];

  logic [WIDTH-1:0] res, lres;
  logic             wr, wr2, upd_zn, zn_byte, shin;
  logic             nc, nz, nn, nv;

  always_comb begin
    res     = dst_val;
    lres    = '0;
    wr      = 1'b0;
    wr2     = 1'b0;
    upd_zn  = 1'b0;
    zn_byte = bmode;
    shin    = 1'b0;
    nc      = psw_in[0];
    nz      = psw_in[1];
    nn      = psw_in[2];
    nv      = psw_in[3];
    if (is_two) begin
      case (op)
        4'h0, 4'h1, 4'h2, 4'h3: begin
          wr     = 1'b1;
          upd_zn = 1'b1;
          if (bmode) begin
            res = {dst_val[WIDTH-1:HB], bsum[HB-1:0]};
            nc  = bsum[HB];
            nv  = (dst_val[HB-1] == bsel[HB-1]) && (bsum[HB-1] != dst_val[HB-1]);
          end else begin
            res = wsum[WIDTH-1:0];
            nc  = wsum[WIDTH];
            nv  = (dst_val[WIDTH-1] == bsel[WIDTH-1]) && (wsum[WIDTH-1] != dst_val[WIDTH-1]);
          end
        end
        4'h6, 4'h7, 4'h8, 4'h9, 4'hA: begin
          case (op)
            4'h6:    lres = dst_val ^ opnd;
            4'h9:    lres = dst_val & ~opnd;
            4'hA:    lres = dst_val | opnd;
            default: lres = dst_val & opnd;
          endcase
          res    = bmode ? {dst_val[WIDTH-1:HB], lres[HB-1:0]} : lres;
          wr     = op != 4'h8;
          upd_zn = 1'b1;
          nv     = 1'b0;
        end
        4'hC: begin
          if (!instr[7]) begin
            res = bmode ? {dst_val[WIDTH-1:HB], src_val[HB-1:0]} : src_val;
            wr  = 1'b1;
          end else if (!bmode) begin
            res = src_val;
            wr  = 1'b1;
            wr2 = 1'b1;
          end
        end
        4'hD: begin
          if (instr[5:3] == 3'b000) begin
            if (instr[7])   shin = psw_in[0];
            else if (bmode) shin = dst_val[HB-1];
            else            shin = dst_val[WIDTH-1];
            res    = bmode ? {dst_val[WIDTH-1:HB], shin, dst_val[HB-1:1]}
                           : {shin, dst_val[WIDTH-1:1]};
            nc     = dst_val[0];
            wr     = 1'b1;
            upd_zn = 1'b1;
          end
        end
        4'hE: begin
          if (instr[7:4] == 4'b0000) begin
            wr      = 1'b1;
            zn_byte = 1'b0;
            if (instr[3]) begin
              res    = {{HB{dst_val[HB-1]}}, dst_val[HB-1:0]};
              upd_zn = 1'b1;
            end else begin
              res = {dst_val[HB-1:0], dst_val[WIDTH-1:HB]};
            end
          end
        end
        default: ;
      endcase
    end else if (is_imm) begin
      wr = 1'b1;
      case (instr[12:11])
        2'b00:   res = {dst_val[WIDTH-1:HB], imm};
        2'b01:   res = {{HB{1'b0}}, imm};
        2'b10:   res = {{HB{1'b1}}, imm};
        default: res = {imm, dst_val[HB-1:0]};
      endcase
    end
    if (upd_zn) begin
      nz = zn_byte ? (res[HB-1:0] == '0) : (res == '0);
      nn = zn_byte ? res[HB-1] : res[WIDTH-1];
    end
  end

  logic [WIDTH-1:0] instr_q, dst_q;
  logic [3:0]       psw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      wr_en     <= 1'b0;
      wr2_en    <= 1'b0;
      wr2_data  <= '0;
      psw_out   <= '0;
      instr_q   <= '0;
      dst_q     <= '0;
      psw_q     <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid & wr;
      wr2_en    <= in_valid & wr2;
      if (in_valid) begin
        result   <= res;
        wr2_data <= dst_val;
        psw_out  <= {nv, nn, nz, nc};
        instr_q  <= instr;
        dst_q    <= dst_val;
        psw_q    <= psw_in;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !wr_en && !wr2_en); // R1
  AST_BIT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && instr_q[15:8] == 8'h48 |-> !wr_en); // R6
  AST_BYTE_HIGH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && wr_en && instr_q[15:12] == 4'b0100 && instr_q[6] |-> result[WIDTH-1:HB] == dst_q[WIDTH-1:HB]); // R4
  AST_SWAP_ONLY_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    wr2_en |-> wr_en && instr_q[15:6] == 10'b0100110010 && wr2_data == dst_q); // R7
  AST_LOGIC_V_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && instr_q[15:12] == 4'b0100 && (instr_q[11:8] inside {4'h6, 4'h7, 4'h8, 4'h9, 4'hA}) |-> !psw_out[3]); // R5
  AST_IMM_PSW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && instr_q[15:13] == 3'b011 |-> wr_en && psw_out == psw_q); // R10
  AST_NO_WRITE_PSW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !wr_en && instr_q[15:8] != 8'h48 |-> psw_out == psw_q); // R11
endmodule

// File: tb/wb_alu_exec_tb.sv
`timescale 1ns/1ps
module wb_alu_exec_tb;
  logic        clk = 0, rst_n = 0, in_valid = 0;
  logic [15:0] instr = 0, dst_val = 0, src_val = 0;
  logic [3:0]  psw_in = 0;
  logic        out_valid, wr_en, wr2_en;
  logic [15:0] result, wr2_data;
  logic [3:0]  psw_out;

  wb_alu_exec u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .dst_val(dst_val), .src_val(src_val), .psw_in(psw_in), .out_valid(out_valid),
    .result(result), .wr_en(wr_en), .wr2_en(wr2_en), .wr2_data(wr2_data), .psw_out(psw_out));

  always #2.5 clk = ~clk;

  typedef struct {
    logic [15:0] res;
    bit          wr;
    bit          wr2;
    logic [15:0] d2;
    logic [3:0]  psw;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit running = 0, done = 0;

  function automatic exp_t model(input logic [15:0] ins, input logic [15:0] d,
                                 input logic [15:0] s, input logic [3:0] p, input string tag);
    exp_t e;
    int a, b, m, top, sum, r, cin, k;
    int c = p[0], z = p[1], n = p[2], v = p[3];
    bit zn = 0;
    int op = ins[11:8];
    bit by = ins[6];
    e.wr = 0; e.wr2 = 0; e.d2 = d; e.res = d; e.tag = tag;
    m = by ? 255 : 65535; top = by ? 128 : 32768;
    r = 0;
    if (ins[15:12] == 4'b0100) begin
      k = (ins[5:3] == 7) ? 65535 : (ins[5:3] == 0 ? 0 : (1 << (ins[5:3] - 1)));
      b = ins[7] ? k : int'(s);
      a = int'(d) & m; b = b & m;
      if (op <= 3) begin
        if (op >= 2) b = (~b) & m;
        cin = (op == 0) ? 0 : (op == 2) ? 1 : c;
        sum = a + b + cin; r = sum & m;
        c = (sum > m) ? 1 : 0;
        v = (((a & top) == (b & top)) && ((r & top) != (a & top))) ? 1 : 0;
        zn = 1; e.wr = 1;
      end else if (op >= 6 && op <= 10) begin
        case (op)
          6: r = a ^ b;
          9: r = a & ~b & m;
          10: r = a | b;
          default: r = a & b;
        endcase
        v = 0; zn = 1; e.wr = (op != 8);
      end else if (op == 12) begin
        if (ins[7] == 0) begin r = int'(s) & m; e.wr = 1; end
        else if (!by) begin r = int'(s); e.wr = 1; e.wr2 = 1; end
      end else if (op == 13 && ins[5:3] == 0) begin
        r = (a >> 1) | (ins[7] ? (c ? top : 0) : (a & top));
        c = a & 1; zn = 1; e.wr = 1;
      end else if (op == 14 && ins[7:4] == 0) begin
        m = 65535; top = 32768; by = 0; e.wr = 1;
        if (ins[3]) begin r = int'(d[7:0]) | (d[7] ? 16'hFF00 : 0); zn = 1; end
        else r = ((int'(d) & 255) << 8) | (int'(d) >> 8);
      end
      if (e.wr) e.res = by ? ((d & 16'hFF00) | r[15:0]) : r[15:0];
      if (zn) begin z = ((r & m) == 0) ? 1 : 0; n = ((r & top) != 0) ? 1 : 0; end
    end else if (ins[15:13] == 3'b011) begin
      e.wr = 1;
      case (ins[12:11])
        0: e.res = {d[15:8], ins[10:3]};
        1: e.res = {8'h00, ins[10:3]};
        2: e.res = {8'hFF, ins[10:3]};
        default: e.res = {ins[10:3], d[7:0]};
      endcase
    end
    e.psw = {v[0], n[0], z[0], c[0]};
    return e;
  endfunction

  task automatic send(input logic [15:0] ins, input logic [15:0] d,
                      input logic [15:0] s, input logic [3:0] p, input string tag);
    @(negedge clk);
    instr = ins; dst_val = d; src_val = s; psw_in = p; in_valid = 1;
    q.push_back(model(ins, d, s, p, tag));
  endtask

  function automatic logic [15:0] two(input int op, input bit rc, input bit wb,
                                      input int ss, input int dd);
    return {4'b0100, op[3:0], rc, wb, ss[2:0], dd[2:0]};
  endfunction

  always @(negedge clk) begin
    if (running) begin
      if (out_valid) begin
        exp_t e;
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R1 unexpected out_valid: actual 1 expected 0");
        end else begin
          e = q.pop_front();
          if (wr_en !== e.wr || wr2_en !== e.wr2 || psw_out !== e.psw ||
              (e.wr && result !== e.res) || (e.wr2 && wr2_data !== e.d2)) begin
            fails++;
            $display("FAIL %s: actual res=%h wr=%0d wr2=%0d d2=%h psw=%h expected res=%h wr=%0d wr2=%0d d2=%h psw=%h",
                     e.tag, result, wr_en, wr2_en, wr2_data, psw_out, e.res, e.wr, e.wr2, e.d2, e.psw);
          end
        end
      end else begin
        checks++;
        if (wr_en !== 0 || wr2_en !== 0) begin
          fails++;
          $display("FAIL R1 idle write: actual wr=%0d wr2=%0d expected 0 0", wr_en, wr2_en);
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 0 || wr_en !== 0 || wr2_en !== 0 || result !== 0 || psw_out !== 0) begin
      fails++;
      $display("FAIL R1 reset: actual v=%0d wr=%0d wr2=%0d res=%h psw=%h expected all 0",
               out_valid, wr_en, wr2_en, result, psw_out);
    end
    rst_n = 1;
    @(negedge clk);
    running = 1;
    for (int i = 0; i < 8; i++) send(two(0, 1, 0, i, 1), 16'h1000, 16'h5555, 4'h0, "R2 constant source");
    send(two(0, 0, 0, 2, 1), 16'h7FFF, 16'h0001, 4'h0, "R3 ADD overflow");
    send(two(0, 0, 0, 2, 1), 16'hFFFF, 16'h0001, 4'h0, "R3 ADD carry zero");
    send(two(1, 0, 0, 2, 1), 16'h0010, 16'h0020, 4'h1, "R3 ADDC carry in");
    send(two(2, 0, 0, 2, 1), 16'h1234, 16'h1234, 4'h0, "R3 SUB equal");
    send(two(2, 0, 0, 2, 1), 16'h8000, 16'h0001, 4'h0, "R3 SUB overflow");
    send(two(3, 0, 0, 2, 1), 16'h0005, 16'h0005, 4'h0, "R3 SUBC borrow");
    send(two(0, 0, 1, 2, 1), 16'h12FF, 16'h3401, 4'h0, "R4 byte ADD carry");
    send(two(0, 0, 1, 2, 1), 16'hAB7F, 16'h0001, 4'h0, "R4 byte ADD overflow");
    send(two(2, 1, 1, 1, 1), 16'h5500, 16'h0000, 4'h0, "R4 byte SUB constant");
    send(two(6, 0, 0, 2, 1), 16'hF0F0, 16'hFF00, 4'h9, "R5 XOR");
    send(two(7, 0, 1, 2, 1), 16'hF0F0, 16'h0F0F, 4'h9, "R5 AND byte zero");
    send(two(9, 0, 0, 2, 1), 16'hFFFF, 16'h00FF, 4'h8, "R5 BIC");
    send(two(10, 1, 0, 7, 1), 16'h0000, 16'h0000, 4'h8, "R5 BIS constant");
    send(two(8, 0, 0, 2, 1), 16'h8001, 16'h8000, 4'h8, "R6 BIT");
    send(two(12, 0, 0, 2, 1), 16'h1111, 16'hABCD, 4'h5, "R7 MOV word");
    send(two(12, 0, 1, 2, 1), 16'h1111, 16'hABCD, 4'h5, "R7 MOV byte");
    send(two(12, 1, 0, 2, 1), 16'h1111, 16'hABCD, 4'hA, "R7 SWAP");
    send(two(13, 0, 0, 0, 1), 16'h8003, 16'h0, 4'h0, "R8 SRA word");
    send(two(13, 0, 1, 0, 1), 16'h1281, 16'h0, 4'h0, "R8 SRA byte");
    send(two(13, 1, 0, 0, 1), 16'h0001, 16'h0, 4'h0, "R8 RRC zero");
    send(two(13, 1, 1, 0, 1), 16'h7702, 16'h0, 4'h1, "R8 RRC byte carry in");
    send(two(14, 0, 0, 0, 1), 16'h12F0, 16'h0, 4'h3, "R9 SWPB");
    send(two(14, 0, 0, 1, 1), 16'h1280, 16'h0, 4'h9, "R9 SXT negative");
    send(two(14, 0, 0, 1, 1), 16'hFF00, 16'h0, 4'h4, "R9 SXT zero");
    send(16'h6000 | (16'h5A << 3) | 3, 16'h1234, 0, 4'h7, "R10 load low keep");
    send(16'h6800 | (16'h5A << 3) | 3, 16'h1234, 0, 4'h7, "R10 load low zero");
    send(16'h7000 | (16'h5A << 3) | 3, 16'h1234, 0, 4'h7, "R10 load low ones");
    send(16'h7800 | (16'h5A << 3) | 3, 16'h1234, 0, 4'h7, "R10 load high");
    send(two(4, 0, 0, 2, 1), 16'h1, 16'h1, 4'h6, "R11 unused op 4");
    send(two(15, 0, 0, 2, 1), 16'h1, 16'h1, 4'h6, "R11 unused op 15");
    send(two(13, 0, 0, 1, 1), 16'h1, 16'h1, 4'h6, "R11 shift nonzero field");
    send(two(12, 1, 1, 2, 1), 16'h1, 16'h1, 4'h6, "R11 swap with W set");
    send(two(14, 0, 0, 2, 1), 16'h1, 16'h1, 4'h6, "R11 unused single op");
    send(16'h0123, 16'h1, 16'h1, 4'h6, "R11 branch space");
    send(16'h8005, 16'h1, 16'h1, 4'h6, "R11 memory space");
    @(negedge clk) in_valid = 0;
    @(negedge clk);
    for (int i = 0; i < 400; i++) begin
      logic [15:0] ri;
      ri = 16'h4000 | 16'($urandom_range(0, 16'h3FFF));
      send(ri, 16'($urandom), 16'($urandom), 4'($urandom), "R2-R11 mixed (R3 R4 R5 R8)");
      if (i % 37 == 0) begin @(negedge clk) in_valid = 0; end
    end
    @(negedge clk) in_valid = 0;
    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R1 missing results: actual %0d pending expected 0", q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule